// File: doc/BRIEF.md
# Bus-Master DMA Register Window

This block is the I/O register window through which software programs two bus-master DMA channels of a disk controller. A 16-byte aperture splits into one 8-byte slot per channel. The low four bytes of a slot are byte registers: command, a mode byte that both channels share, status, and the channel's transfer-timing byte. The high four bytes form the 32-bit base address of the channel's descriptor table.

Each register has its own write rule. The command byte and the table address are stored as written and exported to the DMA engine. Through this window only the two interrupt-block bits of the mode byte can be written. The status byte mixes preserved, writable and write-one-to-clear bits. The timing bytes and the mode byte are also visible to the configuration logic through side ports, and the block drives the controller's interrupt line from the mode byte.

Only single-byte accesses have an effect. A wider access is dropped when it is a write, and when it is a read it returns all ones across its width. The DMA engine and the behaviour that starts a command are outside this block.

Top module: `bm_dma_window`

## Requirements
- R1: After reset every register reads 0x00 at all 16 offsets, and irq_o is low.
- R2: bus_addr[3] selects the channel. Within a channel, bus_addr[2] selects the table address port, and otherwise bus_addr[1:0] picks the register: 0 command, 1 mode, 2 status, 3 timing.
- R3: An access with bus_size other than 1 changes no register when it is a write. When it is a read it returns ones in the low 8*bus_size bits (bus_size 2 gives 0x0000FFFF, bus_size 4 gives 0xFFFFFFFF).
- R4: A byte write to index 0 stores the whole command byte. Channel c's command byte appears on cmd_o[8c+7:8c].
- R5: A byte write to index 1 of either slot sets mode bits 5:4 (bit 4+c blocks channel c's interrupt) from the written data and leaves every other mode bit as it was. Both slots read the same mode byte.
- R6: A byte write to status sets bits 6:5 to the written value, keeps bit 0, and clears bit 1 or bit 2 where the written bit is one. Bits 7, 4 and 3 always read zero.
- R7: Status bit 0 follows eng_active[c] one cycle later. eng_err_set[c] sets bit 1 and eng_irq_set[c] sets bit 2. A set that arrives in the same cycle as a clearing write wins.
- R8: The timing byte can be written from the bus at index 3 and from cfg_tim_wr[c]. When both write in the same cycle, the configuration write wins. The byte appears on tim_o[8c+7:8c].
- R9: The table address port takes byte writes at offsets 4 to 7 (byte lanes 0 to 3) and reads back the same way. Bits 1:0 of the address are always zero. Channel c's address appears on tbl_o[32c+31:32c].
- R10: A rising edge on dev_irq[c] sets mode bit 2+c, and a falling edge clears it. A cfg_mode_wr whose cfg_mode_w1c has bit 2+c set also clears it. irq_o is high while, for any channel, bit 2+c is set and bit 4+c is clear, and it follows a mode write on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Byte offset in the aperture |
| bus_size | input | 3 | Access width in bytes |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data; byte accesses use bits 7:0 |
| bus_rdata | output | 32 | Read data, combinational, zero when not reading |
| dev_irq | input | 2 | Interrupt level from each channel's drive side |
| cfg_mode_wr | input | 1 | Configuration write to the mode byte |
| cfg_mode_w1c | input | 8 | Mode bits to clear on cfg_mode_wr |
| cfg_tim_wr | input | 2 | Configuration write to each channel's timing byte |
| cfg_tim_data | input | 8 | Data for cfg_tim_wr |
| eng_active | input | 2 | Per-channel active level from the DMA engine |
| eng_err_set | input | 2 | Per-channel error set pulse |
| eng_irq_set | input | 2 | Per-channel interrupt set pulse |
| cmd_o | output | 16 | Command bytes |
| stat_o | output | 16 | Status bytes |
| mode_o | output | 8 | Shared mode byte |
| tim_o | output | 16 | Timing bytes |
| tbl_o | output | 64 | Descriptor table addresses |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions take bus_size to be stable during an access. They also take eng_err_set to stay low in the cycle where a status clear is checked, and bus_rdata to be looked at only while bus_rd is high. The bench drives every strobe for exactly one cycle. It changes the side inputs only at the falling clock edge and raises an engine set pulse together with a clearing write only in the one scenario built for R7, which the W1C property excludes by its antecedent. Reads are sampled shortly after the falling edge, well before the next rising edge.

// File: rtl/bm_pkg.sv
package bm_pkg;
  typedef enum logic [1:0] {
    IDX_CMD  = 2'd0,
    IDX_MODE = 2'd1,
    IDX_STAT = 2'd2,
    IDX_TIM  = 2'd3
  } bm_idx_e;

  localparam int STAT_ACT = 0;
  localparam int STAT_ERR = 1;
  localparam int STAT_INT = 2;
  localparam int STAT_CAP_LO = 5;
  localparam int STAT_CAP_HI = 6;

  localparam int MODE_INT_BASE = 2;
  localparam int MODE_BLK_BASE = 4;
endpackage

// File: rtl/bm_decode.sv
module bm_decode #(
  parameter int NCH    = 2,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4,
  parameter int SIZE_W = 3,
  localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [SIZE_W-1:0] size,
  input  logic              wr,
  input  logic              rd,
  output logic              byte_acc,
  output logic              byte_wr,
  output logic              byte_rd,
  output logic [CH_W-1:0]   ch_idx,
  output bm_pkg::bm_idx_e   reg_idx,
  output logic              in_tbl,
  output logic [1:0]        lane,
  output logic [DATA_W-1:0] rd_fill
);
  localparam int NBYTES = DATA_W / 8;

  always_comb begin
    byte_acc = (size == SIZE_W'(1));
    byte_wr  = wr && byte_acc;
    byte_rd  = rd && byte_acc;
    ch_idx   = CH_W'(addr[ADDR_W-1:3]);
    in_tbl   = addr[2];
    lane     = addr[1:0];
    reg_idx  = bm_pkg::bm_idx_e'(addr[1:0]);
  end

  always_comb begin
    for (int b = 0; b < NBYTES; b++) begin
      rd_fill[b*8 +: 8] = (int'(size) > b) ? 8'hFF : 8'h00;
    end
  end
endmodule

// File: rtl/bm_mode.sv
module bm_mode #(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_we,
  input  logic [7:0]     bus_wdata,
  input  logic [NCH-1:0] dev_irq,
  input  logic           cfg_wr,
  input  logic [7:0]     cfg_w1c,
  output logic [7:0]     mode_q,
  output logic           irq
);
  import bm_pkg::*;

  logic [7:0]     mode_d;
  logic [NCH-1:0] dev_q;
  logic           mode_en;

  always_comb begin
    mode_d = mode_q;
    for (int c = 0; c < NCH; c++) begin
      if (bus_we) begin
        mode_d[MODE_BLK_BASE + c] = bus_wdata[MODE_BLK_BASE + c];
      end
      if (dev_irq[c] && !dev_q[c]) begin
        mode_d[MODE_INT_BASE + c] = 1'b1;
      end else if (!dev_irq[c] && dev_q[c]) begin
        mode_d[MODE_INT_BASE + c] = 1'b0;
      end else if (cfg_wr && cfg_w1c[MODE_INT_BASE + c]) begin
        mode_d[MODE_INT_BASE + c] = 1'b0;
      end
    end
    mode_en = (mode_d != mode_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      dev_q  <= '0;
    end else begin
      dev_q <= dev_irq;
      if (mode_en) begin
        mode_q <= mode_d;
      end
    end
  end

  always_comb begin
    irq = 1'b0;
    for (int c = 0; c < NCH; c++) begin
      irq = irq | (mode_q[MODE_INT_BASE + c] & ~mode_q[MODE_BLK_BASE + c]);
    end
  end
endmodule

// File: rtl/bm_chan.sv
module bm_chan (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  bm_pkg::bm_idx_e reg_idx,
  input  logic            in_tbl,
  input  logic [1:0]      lane,
  input  logic [7:0]      wdata,
  input  logic [7:0]      mode_i,
  input  logic            cfg_tim_wr,
  input  logic [7:0]      cfg_tim_data,
  input  logic            eng_active,
  input  logic            eng_err_set,
  input  logic            eng_irq_set,
  output logic [7:0]      cmd_q,
  output logic [7:0]      stat_q,
  output logic [7:0]      tim_q,
  output logic [31:0]     tbl_q,
  output logic [7:0]      rd_byte
);
  import bm_pkg::*;

  logic        reg_wr, cmd_en, stat_wr, tim_en, tbl_en;
  logic [7:0]  stat_d, tim_d, tbl_byte;
  logic [1:0]  w1c;
  logic [31:0] tbl_d;

  always_comb begin
    reg_wr  = wr_en && !in_tbl;
    cmd_en  = reg_wr && (reg_idx == IDX_CMD);
    stat_wr = reg_wr && (reg_idx == IDX_STAT);
    tim_en  = cfg_tim_wr || (reg_wr && (reg_idx == IDX_TIM));
    tbl_en  = wr_en && in_tbl;
  end

  always_comb begin
    w1c    = stat_wr ? wdata[STAT_INT:STAT_ERR] : 2'b00;
    stat_d = '0;
    stat_d[STAT_ACT] = eng_active;
    stat_d[STAT_ERR] = (stat_q[STAT_ERR] & ~w1c[0]) | eng_err_set;
    stat_d[STAT_INT] = (stat_q[STAT_INT] & ~w1c[1]) | eng_irq_set;
    stat_d[STAT_CAP_HI:STAT_CAP_LO] = stat_wr ? wdata[STAT_CAP_HI:STAT_CAP_LO]
                                              : stat_q[STAT_CAP_HI:STAT_CAP_LO];
  end

  always_comb begin
    tim_d = cfg_tim_wr ? cfg_tim_data : wdata;
  end

  always_comb begin
    tbl_d    = tbl_q;
    tbl_byte = (lane == 2'd0) ? {wdata[7:2], 2'b00} : wdata;
    tbl_d[lane*8 +: 8] = tbl_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      stat_q <= '0;
      tim_q  <= '0;
      tbl_q  <= '0;
    end else begin
      stat_q <= stat_d;
      if (cmd_en) cmd_q <= wdata;
      if (tim_en) tim_q <= tim_d;
      if (tbl_en) tbl_q <= tbl_d;
    end
  end

  always_comb begin
    if (in_tbl) begin
      rd_byte = tbl_q[lane*8 +: 8];
    end else begin
      unique case (reg_idx)
        IDX_CMD:  rd_byte = cmd_q;
        IDX_MODE: rd_byte = mode_i;
        IDX_STAT: rd_byte = stat_q;
        default:  rd_byte = tim_q;
      endcase
    end
  end
endmodule

// File: rtl/bm_dma_window.sv
module bm_dma_window #(
  parameter int NCH    = 2,
  parameter int DATA_W = 32,
  parameter int SIZE_W = 3,
  localparam int ADDR_W = 3 + ((NCH > 1) ? $clog2(NCH) : 1),
  localparam int CH_W   = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [SIZE_W-1:0]   bus_size,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic [NCH-1:0]      dev_irq,
  input  logic                cfg_mode_wr,
  input  logic [7:0]          cfg_mode_w1c,
  input  logic [NCH-1:0]      cfg_tim_wr,
  input  logic [7:0]          cfg_tim_data,
  input  logic [NCH-1:0]      eng_active,
  input  logic [NCH-1:0]      eng_err_set,
  input  logic [NCH-1:0]      eng_irq_set,
  output logic [NCH*8-1:0]    cmd_o,
  output logic [NCH*8-1:0]    stat_o,
  output logic [7:0]          mode_o,
  output logic [NCH*8-1:0]    tim_o,
  output logic [NCH*32-1:0]   tbl_o,
  output logic                irq_o
);
  import bm_pkg::*;

  logic              byte_acc, byte_wr, byte_rd, in_tbl;
  logic [CH_W-1:0]   ch_idx;
  bm_idx_e           reg_idx;
  logic [1:0]        lane;
  logic [DATA_W-1:0] rd_fill;
  logic              mode_we;
  logic [7:0]        chan_rd [NCH];

  bm_decode #(
    .NCH(NCH), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SIZE_W(SIZE_W)
  ) u_dec (
    .addr(bus_addr), .size(bus_size), .wr(bus_wr), .rd(bus_rd),
    .byte_acc(byte_acc), .byte_wr(byte_wr), .byte_rd(byte_rd),
    .ch_idx(ch_idx), .reg_idx(reg_idx), .in_tbl(in_tbl), .lane(lane),
    .rd_fill(rd_fill)
  );

  assign mode_we = byte_wr && !in_tbl && (reg_idx == IDX_MODE);

  bm_mode #(.NCH(NCH)) u_mode (
    .clk(clk), .rst_n(rst_n),
    .bus_we(mode_we), .bus_wdata(bus_wdata[7:0]),
    .dev_irq(dev_irq), .cfg_wr(cfg_mode_wr), .cfg_w1c(cfg_mode_w1c),
    .mode_q(mode_o), .irq(irq_o)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic ch_wr;
    assign ch_wr = byte_wr && (ch_idx == CH_W'(c));
    bm_chan u_chan (
      .clk(clk), .rst_n(rst_n),
      .wr_en(ch_wr), .reg_idx(reg_idx), .in_tbl(in_tbl), .lane(lane),
      .wdata(bus_wdata[7:0]), .mode_i(mode_o),
      .cfg_tim_wr(cfg_tim_wr[c]), .cfg_tim_data(cfg_tim_data),
      .eng_active(eng_active[c]), .eng_err_set(eng_err_set[c]),
      .eng_irq_set(eng_irq_set[c]),
      .cmd_q(cmd_o[c*8 +: 8]), .stat_q(stat_o[c*8 +: 8]),
      .tim_q(tim_o[c*8 +: 8]), .tbl_q(tbl_o[c*32 +: 32]),
      .rd_byte(chan_rd[c])
    );
  end

  always_comb begin
    if (byte_rd) begin
      bus_rdata = {{(DATA_W-8){1'b0}}, chan_rd[ch_idx]};
    end else if (bus_rd) begin
      bus_rdata = rd_fill;
    end else begin
      bus_rdata = '0;
    end
  end
endmodule

// File: rtl/bm_window_chk.sv
module bm_window_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [3:0]  bus_addr,
  input logic [2:0]  bus_size,
  input logic        bus_wr,
  input logic        bus_rd,
  input logic [31:0] bus_wdata,
  input logic [31:0] bus_rdata,
  input logic [1:0]  eng_err_set,
  input logic [15:0] cmd_o,
  input logic [15:0] stat_o,
  input logic [7:0]  mode_o,
  input logic [63:0] tbl_o,
  input logic        irq_o
);
  assert_wide_wr_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_size != 3'd1) |=> ($stable(cmd_o) && $stable(tbl_o)));

  assert_wide_rd_ones_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_size == 3'd4) |-> (bus_rdata == 32'hFFFF_FFFF));

  assert_mode_blk_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_size == 3'd1 && !bus_addr[2] && bus_addr[1:0] == 2'd1)
    |=> (mode_o[5:4] == $past(bus_wdata[5:4])));

  assert_blk_masks_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_size == 3'd1 && !bus_addr[2] && bus_addr[1:0] == 2'd1 &&
     bus_wdata[5:4] == 2'b11) |=> !irq_o);

  assert_tbl_low_bits_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tbl_o[1:0] == 2'b00) && (tbl_o[33:32] == 2'b00));

  assert_stat_w1c_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_size == 3'd1 && bus_addr == 4'h2 && bus_wdata[1] && !eng_err_set[0])
    |=> !stat_o[1]);
endmodule

bind bm_dma_window bm_window_chk u_chk (.*);

// File: tb/test_bm_dma_window.sv
module test_bm_dma_window;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  bus_addr;
  logic [2:0]  bus_size;
  logic        bus_wr, bus_rd;
  logic [31:0] bus_wdata, bus_rdata;
  logic [1:0]  dev_irq;
  logic        cfg_mode_wr;
  logic [7:0]  cfg_mode_w1c;
  logic [1:0]  cfg_tim_wr;
  logic [7:0]  cfg_tim_data;
  logic [1:0]  eng_active, eng_err_set, eng_irq_set;
  logic [15:0] cmd_o, stat_o, tim_o;
  logic [7:0]  mode_o;
  logic [63:0] tbl_o;
  logic        irq_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  bm_dma_window i_bm_dma_window (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_size(bus_size),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dev_irq(dev_irq), .cfg_mode_wr(cfg_mode_wr), .cfg_mode_w1c(cfg_mode_w1c),
    .cfg_tim_wr(cfg_tim_wr), .cfg_tim_data(cfg_tim_data),
    .eng_active(eng_active), .eng_err_set(eng_err_set), .eng_irq_set(eng_irq_set),
    .cmd_o(cmd_o), .stat_o(stat_o), .mode_o(mode_o), .tim_o(tim_o),
    .tbl_o(tbl_o), .irq_o(irq_o)
  );

  task automatic chk(string req, string what, logic [63:0] got, logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic bus_write(logic [3:0] a, logic [2:0] sz, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_size = sz; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(logic [3:0] a, logic [2:0] sz, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_size = sz; bus_rd = 1'b1;
    #1 d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int a = 0; a < 16; a++) begin
      bus_read(4'(a), 3'd1, d);
      chk("R1", $sformatf("reset read off %0d", a), 64'(d), 64'h0);
    end
    chk("R1", "reset irq", 64'(irq_o), 64'h0);
  endtask

  task automatic t_cmd();
    logic [31:0] d;
    bus_write(4'h0, 3'd1, 32'hA5);
    bus_write(4'h8, 3'd1, 32'h3C);
    bus_read(4'h0, 3'd1, d);
    chk("R4", "cmd0 readback", 64'(d), 64'hA5);
    bus_read(4'h8, 3'd1, d);
    chk("R2", "cmd1 readback in slot 1", 64'(d), 64'h3C);
    chk("R4", "cmd_o", 64'(cmd_o), 64'h3CA5);
  endtask

  task automatic t_mode();
    logic [31:0] d;
    @(negedge clk); dev_irq = 2'b01;
    @(negedge clk);
    chk("R10", "mode after dev_irq0 rise", 64'(mode_o), 64'h04);
    chk("R10", "irq after rise", 64'(irq_o), 64'h1);
    bus_write(4'h1, 3'd1, 32'hFF);
    chk("R5", "mode after write ff", 64'(mode_o), 64'h34);
    chk("R10", "irq blocked", 64'(irq_o), 64'h0);
    bus_read(4'h9, 3'd1, d);
    chk("R5", "mode shared via slot 1", 64'(d), 64'h34);
    bus_write(4'h9, 3'd1, 32'h00);
    chk("R5", "mode after write 00", 64'(mode_o), 64'h04);
    chk("R10", "irq unblocked", 64'(irq_o), 64'h1);
    @(negedge clk); cfg_mode_wr = 1'b1; cfg_mode_w1c = 8'h04;
    @(negedge clk); cfg_mode_wr = 1'b0; cfg_mode_w1c = 8'h00;
    chk("R10", "mode after cfg w1c", 64'(mode_o), 64'h00);
    chk("R10", "irq after cfg w1c", 64'(irq_o), 64'h0);
    @(negedge clk); dev_irq = 2'b11;
    @(negedge clk);
    chk("R10", "mode after dev_irq1 rise", 64'(mode_o), 64'h08);
    @(negedge clk); dev_irq = 2'b00;
    @(negedge clk);
    chk("R10", "mode after falls", 64'(mode_o), 64'h00);
    chk("R10", "irq after falls", 64'(irq_o), 64'h0);
  endtask

  task automatic t_status();
    @(negedge clk); eng_active = 2'b01; eng_err_set = 2'b01; eng_irq_set = 2'b01;
    @(negedge clk); eng_err_set = 2'b00; eng_irq_set = 2'b00;
    chk("R7", "status after engine sets", 64'(stat_o[7:0]), 64'h07);
    bus_write(4'h2, 3'd1, 32'hFF);
    chk("R6", "status after write ff", 64'(stat_o[7:0]), 64'h61);
    bus_write(4'h2, 3'd1, 32'h00);
    chk("R6", "status after write 00", 64'(stat_o[7:0]), 64'h01);
    @(negedge clk); eng_active = 2'b00;
    @(negedge clk);
    chk("R7", "active follows", 64'(stat_o[7:0]), 64'h00);
    @(negedge clk);
    bus_addr = 4'h2; bus_size = 3'd1; bus_wdata = 32'h02; bus_wr = 1'b1;
    eng_err_set = 2'b01;
    @(negedge clk); bus_wr = 1'b0; eng_err_set = 2'b00;
    chk("R7", "set beats clear", 64'(stat_o[7:0]), 64'h02);
    bus_write(4'h2, 3'd1, 32'h02);
    chk("R6", "w1c error bit", 64'(stat_o[7:0]), 64'h00);
    chk("R6", "channel 1 untouched", 64'(stat_o[15:8]), 64'h00);
  endtask

  task automatic t_timing();
    bus_write(4'h3, 3'd1, 32'h5A);
    bus_write(4'hB, 3'd1, 32'hC3);
    chk("R8", "tim_o from bus", 64'(tim_o), 64'hC35A);
    @(negedge clk);
    bus_addr = 4'h3; bus_size = 3'd1; bus_wdata = 32'h22; bus_wr = 1'b1;
    cfg_tim_wr = 2'b01; cfg_tim_data = 8'h11;
    @(negedge clk); bus_wr = 1'b0; cfg_tim_wr = 2'b00;
    chk("R8", "config wins", 64'(tim_o), 64'hC311);
  endtask

  task automatic t_table();
    logic [31:0] d;
    bus_write(4'h4, 3'd1, 32'h13);
    bus_write(4'h5, 3'd1, 32'h22);
    bus_write(4'h6, 3'd1, 32'h33);
    bus_write(4'h7, 3'd1, 32'h44);
    bus_write(4'hC, 3'd1, 32'hFF);
    bus_write(4'hF, 3'd1, 32'h80);
    chk("R9", "tbl0", 64'(tbl_o[31:0]), 64'h4433_2210);
    chk("R9", "tbl1", 64'(tbl_o[63:32]), 64'h8000_00FC);
    bus_read(4'h4, 3'd1, d);
    chk("R9", "tbl0 lane0 read", 64'(d), 64'h10);
    bus_read(4'hF, 3'd1, d);
    chk("R2", "tbl1 lane3 read", 64'(d), 64'h80);
  endtask

  task automatic t_wide();
    logic [31:0] d;
    bus_write(4'h0, 3'd4, 32'hFFFF_FFFF);
    chk("R3", "cmd after wide write", 64'(cmd_o), 64'h3CA5);
    bus_write(4'h4, 3'd2, 32'h0000_FFFF);
    chk("R3", "tbl after wide write", 64'(tbl_o[31:0]), 64'h4433_2210);
    bus_write(4'hB, 3'd2, 32'h0000_0000);
    chk("R3", "tim after wide write", 64'(tim_o), 64'hC311);
    bus_read(4'h0, 3'd2, d);
    chk("R3", "read size 2", 64'(d), 64'h0000_FFFF);
    bus_read(4'h8, 3'd4, d);
    chk("R3", "read size 4", 64'(d), 64'hFFFF_FFFF);
  endtask

  function automatic void summary();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    end
  endfunction

  initial begin
    #(200000 * 4);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_size = 3'd1; bus_wr = 1'b0; bus_rd = 1'b0;
    bus_wdata = '0; dev_irq = '0; cfg_mode_wr = 1'b0; cfg_mode_w1c = '0;
    cfg_tim_wr = '0; cfg_tim_data = '0; eng_active = '0; eng_err_set = '0;
    eng_irq_set = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_cmd();
    t_mode();
    t_status();
    t_timing();
    t_table();
    t_wide();
    summary();
    $finish;
  end
endmodule